// File: doc/BRIEF.md
# Byte-Memory I2C Target

This block is an I2C target that answers one 7-bit device address and holds a small byte-wide memory behind an internal pointer. It samples the open-drain SCL and SDA lines with its own system clock and finds bus conditions and clock edges on the synchronised copies. It drives SDA in only one way: by asking the pad to pull the line low. Clock stretching and 10-bit addressing are not supported.

A master first writes the target's address with the direction bit clear. The next byte becomes the memory pointer, and every byte after that is stored at the pointer, which then advances. To read, the master sets the pointer this way, issues a repeated START with the direction bit set, and clocks bytes out of the memory. The pointer advances after each byte. The reads go on while the master acknowledges and end at its NACK.

Top module: `i2c_mem_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal the parameter `DEV_ADDR` (default 7'h10) by holding SDA low through the ninth SCL clock. Any other address gets no acknowledge. The rest of that transaction leaves the memory and the pointer unchanged, and the target keeps SDA released.
- R2: Bit 0 of the address byte selects the direction: 0 is a write and 1 is a read.
- R3: In a write, the first byte after the address loads the pointer. The target acknowledges it when its value is below `MEM_DEPTH`.
- R4: Each later byte of the write is acknowledged and stored at the pointer, which then increments. Past `MEM_DEPTH-1` it wraps to 0.
- R5: A pointer byte of `MEM_DEPTH` or more is not acknowledged and leaves the pointer unchanged. Data bytes after it in the same transaction are neither acknowledged nor stored.
- R6: The pointer is kept across a repeated START. A read sends the byte at the pointer most significant bit first, then increments the pointer, wrapping at `MEM_DEPTH`.
- R7: While the master acknowledges (SDA low on the ninth clock), the target sends the next byte. After a NACK it releases SDA and stays silent until the next START.
- R8: A START (SDA falling while SCL is high) restarts address decoding at bit 0, even in the middle of a byte. A STOP (SDA rising while SCL is high) returns the target to idle with SDA released.
- R9: The target starts pulling SDA low only while SCL is low.
- R10: After reset, SDA is released, the pointer is 0 and every memory byte reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Level of the SCL line |
| sda_in | input | 1 | Level of the SDA line |
| sda_pull_low | output | 1 | 1 asks the pad to pull SDA low, 0 releases it |

## Verification
The bench builds the block with its defaults: a 16-byte memory and device address 7'h10. With a memory this small, the bench can sweep every one of the 128 possible address bytes, every pointer value from 0 to 31 (both sides of the range limit), and a 17-byte write that wraps the pointer. It can then read the whole memory back across the wrap point and compare each byte with a model held in the bench. Further cases cover a read to a wrong address, the silence after a NACK, and a START in the middle of a byte.

// File: rtl/i2c_tgt_pkg.sv
// Shared types for the I2C byte-memory target.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_tgt_pkg;

    // Transaction phases of the target.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,  // waiting for START
        ST_ADDR   = 3'd1,  // receiving address byte
        ST_WPTR   = 3'd2,  // receiving pointer byte
        ST_WDATA  = 3'd3,  // receiving data bytes
        ST_READ   = 3'd4,  // sending data bytes
        ST_IGNORE = 3'd5   // not addressed or aborted, silent until START/STOP
    } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
// Multi-stage synchroniser for asynchronous bus lines.
// Assumes: inputs are quasi-static levels; reset value is the idle-high bus.
module i2c_tgt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift each line through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_tgt_events.sv
// Finds SCL edges and START/STOP conditions on synchronised line levels.
// Assumes: inputs already synchronised to clk; outputs are single-cycle pulses.
module i2c_tgt_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_prev;
    logic sda_prev;

    // Remember last synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    // Decode clock edges and bus conditions.
    always_comb begin
        scl_rise  = !scl_prev && scl_s;
        scl_fall  = scl_prev && !scl_s;
        start_det = scl_prev && scl_s && sda_prev && !sda_s;
        stop_det  = scl_prev && scl_s && !sda_prev && sda_s;
    end

endmodule

// File: rtl/i2c_tgt_mem.sv
// Byte memory with one synchronous write port and one combinational read port.
// Assumes: DEPTH is a power of two; contents cleared by reset.
module i2c_tgt_mem #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cells [DEPTH];

    // Clear on reset, store on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/i2c_mem_target.sv
// I2C target with a pointer-addressed byte memory.
// Assumes: clk at least ~8x faster than SCL; no clock stretching; 7-bit
// addressing; MEM_DEPTH a power of two no larger than 256.
module i2c_mem_target #(
    parameter logic [6:0] DEV_ADDR  = 7'h10,
    parameter int         MEM_DEPTH = 16,
    parameter int         SYNC_STG  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_pull_low
);
    import i2c_tgt_pkg::*;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = $clog2(MEM_DEPTH);
    localparam int CNT_W  = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(BYTE_W + 1);

    logic [1:0]        sync_vec;
    logic              scl_s, sda_s;
    logic              scl_rise, scl_fall, start_det, stop_det;
    tgt_state_e        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shift_in;
    logic [BYTE_W-1:0] tx_byte;
    logic [PTR_W-1:0]  ptr;
    logic              rw_bit;
    logic              master_nack;
    logic              drive_low;
    logic              wr_en;
    logic [BYTE_W-1:0] rd_data;
    logic              addr_hit;
    logic              ptr_ok;
    logic [2:0]        tx_idx;

    i2c_tgt_sync #(.WIDTH(2), .STAGES(SYNC_STG)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({scl_in, sda_in}),
        .sync_out (sync_vec)
    );
    assign scl_s = sync_vec[1];
    assign sda_s = sync_vec[0];

    i2c_tgt_events i_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_mem #(.DEPTH(MEM_DEPTH), .DATA_W(BYTE_W)) i_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (shift_in),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );

    // Byte decode helpers and the memory write strobe.
    always_comb begin
        addr_hit = (shift_in[7:1] == DEV_ADDR);
        ptr_ok   = (int'(shift_in) < MEM_DEPTH);
        tx_idx   = 3'(7 - int'(bit_cnt));
        wr_en    = (state == ST_WDATA) && scl_fall && (bit_cnt == CNT_ACK)
                   && !start_det && !stop_det;
    end

    // Transaction sequencer: bit counting, acknowledge and data drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            shift_in    <= '0;
            tx_byte     <= '0;
            ptr         <= '0;
            rw_bit      <= 1'b0;
            master_nack <= 1'b0;
            drive_low   <= 1'b0;
        end else if (start_det) begin
            state     <= ST_ADDR;
            bit_cnt   <= '0;
            drive_low <= 1'b0;
        end else if (stop_det) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            drive_low <= 1'b0;
        end else if (state != ST_IDLE) begin
            if (scl_rise) begin
                if (bit_cnt < CNT_ACK) begin
                    shift_in <= {shift_in[BYTE_W-2:0], sda_s};
                    bit_cnt  <= bit_cnt + 1'b1;
                end else if (bit_cnt == CNT_ACK) begin
                    master_nack <= sda_s;
                    bit_cnt     <= CNT_DONE;
                end
            end else if (scl_fall) begin
                if (bit_cnt == CNT_ACK) begin
                    // Eight bits done: decide the acknowledge.
                    case (state)
                        ST_ADDR: begin
                            if (addr_hit) begin
                                rw_bit    <= shift_in[0];
                                drive_low <= 1'b1;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                        ST_WPTR: begin
                            if (ptr_ok) begin
                                ptr       <= shift_in[PTR_W-1:0];
                                drive_low <= 1'b1;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                        ST_WDATA: begin
                            ptr       <= ptr + 1'b1;
                            drive_low <= 1'b1;
                        end
                        default: drive_low <= 1'b0;
                    endcase
                end else if (bit_cnt == CNT_DONE) begin
                    // Ninth clock over: release and move to next byte.
                    bit_cnt   <= '0;
                    drive_low <= 1'b0;
                    case (state)
                        ST_ADDR: begin
                            if (rw_bit) begin
                                state     <= ST_READ;
                                tx_byte   <= rd_data;
                                ptr       <= ptr + 1'b1;
                                drive_low <= !rd_data[BYTE_W-1];
                            end else begin
                                state <= ST_WPTR;
                            end
                        end
                        ST_WPTR: state <= ST_WDATA;
                        ST_READ: begin
                            if (master_nack) begin
                                state <= ST_IGNORE;
                            end else begin
                                tx_byte   <= rd_data;
                                ptr       <= ptr + 1'b1;
                                drive_low <= !rd_data[BYTE_W-1];
                            end
                        end
                        default: ;
                    endcase
                end else if (state == ST_READ && bit_cnt != '0) begin
                    drive_low <= !tx_byte[tx_idx];
                end
            end
        end
    end

    assign sda_pull_low = drive_low;

    // A START always re-arms address decoding at bit 0.
    assert_start_rearms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bit_cnt == '0 && !sda_pull_low));

    // A STOP always returns to idle.
    assert_stop_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_pull_low));

    // SDA pull-down begins only while synchronised SCL is low.
    assert_pull_while_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low) |-> !scl_s);

    // Silent after NACK or address mismatch.
    assert_silent_when_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_pull_low);

    // Idle target never holds SDA.
    assert_released_in_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull_low);

endmodule

// File: tb/test_i2c_mem_target.sv
module test_i2c_mem_target;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 5;       // system clocks per SCL quarter
    localparam int DEPTH      = 16;
    localparam logic [6:0] DEV = 7'h10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull_low;
    logic sda_bus;

    int checks = 0;
    int errors = 0;
    int r9_viol = 0;
    bit done = 1'b0;
    logic [7:0] exp_mem [DEPTH];

    assign sda_bus = m_sda & ~sda_pull_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_mem_target i_i2c_mem_target (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl),
        .sda_in       (sda_bus),
        .sda_pull_low (sda_pull_low)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    // R8: START / repeated START from either idle or SCL low.
    task automatic do_start();
        wq(); m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0;
    endtask

    task automatic do_stop();
        wq(); m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            wq(); m_sda = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        wq(); m_sda = 1'b1; wq(); scl = 1'b1; wq(); ack = !sda_bus; wq(); scl = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wq(); m_sda = 1'b1; wq(); scl = 1'b1; wq(); b[i] = sda_bus; wq(); scl = 1'b0;
        end
        wq(); m_sda = give_ack ? 1'b0 : 1'b1; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 29 + 59) & 255);
    endfunction

    // R9 monitor: target pull-down must not change while SCL is high.
    logic prev_pull = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_pull_low && !prev_pull && scl) r9_viol++;
        prev_pull <= sda_pull_low;
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        bit ack;
        logic [7:0] rb;
        int p;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(sda_pull_low == 1'b0, "R10 reset release", sda_pull_low, 0);

        // R1: sweep every address with write direction (R2 bit0 = 0).
        for (int a = 0; a < 128; a++) begin
            do_start();
            send_byte({7'(a), 1'b0}, ack);
            chk(ack == (a == int'(DEV)), "R1 address sweep", ack, a == int'(DEV));
            do_stop();
        end

        // R10/R6: read reset memory from pointer 0 (R2 bit0 = 1 reads).
        do_start(); send_byte({DEV, 1'b0}, ack);
        send_byte(8'h00, ack); chk(ack, "R3 pointer 0 ack", ack, 1);
        do_start(); send_byte({DEV, 1'b1}, ack); chk(ack, "R2 read address ack", ack, 1);
        for (int i = 0; i < DEPTH; i++) begin
            recv_byte(i != DEPTH - 1, rb);
            chk(rb == 8'h00, "R10 reset contents", rb, 0);
        end
        do_stop();

        // R4: 17-byte write from pointer 0, last byte wraps to 0.
        do_start(); send_byte({DEV, 1'b0}, ack); send_byte(8'h00, ack);
        for (int i = 0; i <= DEPTH; i++) begin
            send_byte(pat(i), ack);
            chk(ack, "R4 data ack", ack, 1);
            exp_mem[i % DEPTH] = pat(i);
        end
        do_stop();

        // R6/R7: set pointer 5, repeated START, read 20 bytes across the wrap.
        do_start(); send_byte({DEV, 1'b0}, ack); send_byte(8'd5, ack);
        do_start(); send_byte({DEV, 1'b1}, ack);
        for (int i = 0; i < 20; i++) begin
            recv_byte(i != 19, rb);
            chk(rb == exp_mem[(5 + i) % DEPTH], "R6 read sequence", rb, exp_mem[(5 + i) % DEPTH]);
        end
        // R7: after NACK the target stays released.
        recv_byte(1'b0, rb);
        chk(rb == 8'hFF, "R7 silent after nack", rb, 8'hFF);
        do_stop();

        // R3/R5: pointer sweep 0..31, out-of-range data ignored.
        for (int v = 0; v < 32; v++) begin
            do_start(); send_byte({DEV, 1'b0}, ack);
            send_byte(8'(v), ack);
            chk(ack == (v < DEPTH), "R5 pointer range ack", ack, v < DEPTH);
            if (v >= DEPTH) begin
                send_byte(8'hEE, ack);
                chk(!ack, "R5 data after bad pointer nack", ack, 0);
            end
            do_stop();
        end
        // Pointer still 15 (last valid); memory unchanged.
        p = DEPTH - 1;
        do_start(); send_byte({DEV, 1'b1}, ack);
        for (int i = 0; i < DEPTH; i++) begin
            recv_byte(i != DEPTH - 1, rb);
            chk(rb == exp_mem[(p + i) % DEPTH], "R5 pointer and memory kept", rb, exp_mem[(p + i) % DEPTH]);
        end
        do_stop();

        // R1: read to a wrong address gets no ACK and bus stays high.
        do_start(); send_byte({DEV ^ 7'h01, 1'b1}, ack);
        chk(!ack, "R1 wrong read address nack", ack, 0);
        recv_byte(1'b0, rb);
        chk(rb == 8'hFF, "R1 wrong address silent", rb, 8'hFF);
        do_stop();

        // R8: START in mid-byte restarts address decoding.
        do_start(); send_bits({DEV, 1'b0} ^ 8'hA5, 3);
        do_start(); send_byte({DEV, 1'b0}, ack);
        chk(ack, "R8 restart mid byte", ack, 1);
        send_byte(8'd2, ack);
        chk(ack, "R8 pointer after restart", ack, 1);
        do_stop();
        do_start(); send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b0, rb);
        chk(rb == exp_mem[2], "R8 read after restart", rb, exp_mem[2]);
        do_stop();
        repeat (4) @(negedge clk);
        chk(sda_pull_low == 1'b0, "R8 released after stop", sda_pull_low, 0);

        chk(r9_viol == 0, "R9 pull only while SCL low", r9_viol, 0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule